// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a small non-pipelined processor built around a single accumulator. Program and data share one memory. The core reaches that memory through a synchronous port with one cycle of read latency. Each instruction is one word. The top four bits hold the operation and the remaining bits hold a memory address. The core handles one instruction at a time and steps it through fetch, decode and execute. Loads and memory-operand adds take one extra read cycle.

Besides the accumulator, the datapath keeps a program counter, an address register, an instruction register and a data register. Register-form arithmetic takes its second operand from the data register. A transfer instruction copies the accumulator into that register. A halt instruction stops the core and raises a flag, so a bench or a supervising block can tell when a program has finished.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `halted` is 0, and the core issues a read (`mem_re`=1) at address 0. The accumulator and the data register reset to zero, so storing either one right after reset writes 0.
- R2: An instruction word carries its opcode in bits [W-1:W-4] and an address in bits [W-5:0]. Opcodes: 0 load, 1 store, 2 add memory, 3 add data register, 4 subtract data register, 5 multiply by data register, 6 invert, 7 copy accumulator to data register, 8 branch, 9 branch if zero, F halt.
- R3: The program counter rises by one during each fetch, so instructions run in address order unless a branch is taken.
- R4: Load (0) sets AC to M[addr]. Store (1) writes AC to M[addr].
- R5: Add memory (2) sets AC to AC + M[addr]. Add register (3) sets AC to AC + DR. Both wrap modulo 2^W.
- R6: Subtract (4) sets AC to AC − DR modulo 2^W. Multiply (5) keeps the low W bits of AC × DR. Invert (6) sets AC to the bitwise complement of AC.
- R7: Opcode 7 sets DR to AC. No other instruction changes DR.
- R8: Branch (8) sets the program counter to the instruction's address field.
- R9: Branch-if-zero (9) jumps to the address field only when AC is 0. Otherwise the next instruction in sequence runs.
- R10: After halt (F), `halted` stays 1 and the core makes no further memory reads or writes until reset.
- R11: Opcodes A to E act as no-ops. They leave AC and DR unchanged and do not write memory.
- R12: A memory read never occurs in the same cycle as a write. Every instruction takes 3 cycles, except load and add memory, which take 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_re | output | 1 | Read request; data returns on `mem_rdata` one cycle later |
| mem_we | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_addr | output | W-4 | Word address for a read or write |
| mem_wdata | output | W | Data to write |
| mem_rdata | input | W | Read data, valid in the cycle after `mem_re` |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions check the rules that hold on every cycle:
- reads and writes never overlap;
- the program counter steps by one in each decode cycle;
- the halted state keeps the memory port quiet;
- a taken branch loads the address register into the program counter, and an untaken branch-if-zero leaves the counter alone;
- the data register changes only on the copy instruction.

The arithmetic values, the choice of path after a conditional branch and the total cycle count of a program can only be shown by running programs. The bench does this by sweeping pairs of operand values, including zero, sign-boundary and all-ones words, and comparing the stored results against values it computes itself.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_LD    = 4'h0,
        OP_ST    = 4'h1,
        OP_ADDM  = 4'h2,
        OP_ADDR  = 4'h3,
        OP_SUB   = 4'h4,
        OP_MUL   = 4'h5,
        OP_NOT   = 4'h6,
        OP_MOV   = 4'h7,
        OP_BR    = 4'h8,
        OP_BZ    = 4'h9,
        OP_HALT  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEMRD  = 3'd3,
        ST_HALT   = 3'd4
    } cpu_state_e;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_MUL  = 3'd3,
        ALU_NOT  = 3'd4
    } alu_op_e;

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu import acc_cpu_pkg::*; #(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;     // low W bits only
            ALU_NOT: y = ~a;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl import acc_cpu_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPW-1:0]   opcode,
    output cpu_state_e       state
);

    cpu_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                if (opcode == OP_LD || opcode == OP_ADDM)
                    state_d = ST_MEMRD;
                else if (opcode == OP_HALT)
                    state_d = ST_HALT;
                else
                    state_d = ST_FETCH;
            end
            ST_MEMRD:  state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu import acc_cpu_pkg::*; #(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               mem_re,
    output logic               mem_we,
    output logic [W-OPW-1:0]   mem_addr,
    output logic [W-1:0]       mem_wdata,
    input  logic [W-1:0]       mem_rdata,
    output logic               halted
);

    localparam int AW = W - OPW;

    typedef struct packed {
        logic [AW-1:0]  pc;
        logic [AW-1:0]  ar;
        logic [OPW-1:0] ir;
        logic [W-1:0]   dr;
        logic [W-1:0]   ac;
    } regs_t;

    regs_t       r_d, r_q;
    cpu_state_e  state;
    alu_op_e     alu_op;
    logic [W-1:0] alu_b, alu_y;

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (r_q.ir),
        .state  (state)
    );

    acc_cpu_alu #(.W(W)) u_alu (
        .op (alu_op),
        .a  (r_q.ac),
        .b  (alu_b),
        .y  (alu_y)
    );

    always_comb begin
        r_d       = r_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.pc;
        mem_wdata = r_q.ac;
        alu_b     = (state == ST_MEMRD) ? mem_rdata : r_q.dr;

        case (r_q.ir)
            OP_ADDM, OP_ADDR: alu_op = ALU_ADD;
            OP_SUB:           alu_op = ALU_SUB;
            OP_MUL:           alu_op = ALU_MUL;
            OP_NOT:           alu_op = ALU_NOT;
            default:          alu_op = ALU_PASS;
        endcase

        case (state)
            ST_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = r_q.pc;
            end
            ST_DECODE: begin
                r_d.ir = mem_rdata[W-1:AW];
                r_d.ar = mem_rdata[AW-1:0];
                r_d.pc = r_q.pc + AW'(1);
            end
            ST_EXEC: begin
                case (r_q.ir)
                    OP_LD, OP_ADDM: begin
                        mem_re   = 1'b1;
                        mem_addr = r_q.ar;
                    end
                    OP_ST: begin
                        mem_we   = 1'b1;
                        mem_addr = r_q.ar;
                    end
                    OP_ADDR, OP_SUB, OP_MUL, OP_NOT: r_d.ac = alu_y;
                    OP_MOV:  r_d.dr = r_q.ac;
                    OP_BR:   r_d.pc = r_q.ar;
                    OP_BZ:   if (r_q.ac == '0) r_d.pc = r_q.ar;
                    default: ;
                endcase
            end
            ST_MEMRD: r_d.ac = alu_y;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign halted = (state == ST_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk import acc_cpu_pkg::*; #(
    parameter int W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input cpu_state_e         state,
    input logic [OPW-1:0]     ir,
    input logic [W-OPW-1:0]   pc,
    input logic [W-OPW-1:0]   ar,
    input logic [W-1:0]       ac,
    input logic [W-1:0]       dr,
    input logic               mem_re,
    input logic               mem_we,
    input logic               halted
);

    localparam int AW = W - OPW;

    p_rw_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (pc == AW'($past(pc) + AW'(1))));

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_re && !mem_we));

    p_mov_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir == OP_MOV) |=> (dr == $past(ac)));

    p_dr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_EXEC && ir == OP_MOV) |=> $stable(dr));

    p_branch_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir == OP_BR) |=> (pc == $past(ar)));

    p_bz_fallthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir == OP_BZ && ac != '0) |=> $stable(pc));

    p_read_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && mem_re) |=> (state == ST_MEMRD));

endmodule

bind acc_cpu acc_cpu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .ir     (r_q.ir),
    .pc     (r_q.pc),
    .ar     (r_q.ar),
    .ac     (r_q.ac),
    .dr     (r_q.dr),
    .mem_re (mem_re),
    .mem_we (mem_we),
    .halted (halted)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_re, mem_we, halted;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem [256];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    acc_cpu #(.W(16)) uut (
        .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re)      mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Release reset, check R1 start state, run to halt, check R10 quiet port.
    task automatic run(input int exp_cycles);
        int cyc;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 halted after reset", {15'd0, halted}, 16'd0);
        check("R1 first read request", {15'd0, mem_re}, 16'd1);
        check("R1 first fetch address", {4'd0, mem_addr}, 16'd0);
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        check("R12 cycles to halt", 16'(cyc), 16'(exp_cycles));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 halted quiet", {14'd0, halted, mem_re | mem_we}, 16'h0002);
        end
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic sweep_pair(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] sel;
        put(8'd0,  ins(4'h0, 12'h081));
        put(8'd1,  ins(4'h7, 12'h000));
        put(8'd2,  ins(4'h0, 12'h080));
        put(8'd3,  ins(4'h3, 12'h000));
        put(8'd4,  ins(4'h1, 12'h090));
        put(8'd5,  ins(4'h0, 12'h080));
        put(8'd6,  ins(4'h4, 12'h000));
        put(8'd7,  ins(4'h1, 12'h091));
        put(8'd8,  ins(4'h0, 12'h080));
        put(8'd9,  ins(4'h5, 12'h000));
        put(8'd10, ins(4'h1, 12'h092));
        put(8'd11, ins(4'h0, 12'h080));
        put(8'd12, ins(4'h6, 12'h000));
        put(8'd13, ins(4'h1, 12'h093));
        put(8'd14, ins(4'h0, 12'h080));
        put(8'd15, ins(4'h2, 12'h081));
        put(8'd16, ins(4'h1, 12'h094));
        put(8'd17, ins(4'h0, 12'h080));
        put(8'd18, ins(4'h9, 12'h015));
        put(8'd19, ins(4'h0, 12'h081));
        put(8'd20, ins(4'h8, 12'h016));
        put(8'd21, ins(4'h0, 12'h082));
        put(8'd22, ins(4'h1, 12'h095));
        put(8'd23, ins(4'hB, 12'h097));
        put(8'd24, ins(4'h1, 12'h096));
        put(8'd25, ins(4'hF, 12'h000));
        put(8'h80, a);
        put(8'h81, b);
        put(8'h82, 16'h5A5A);
        for (int k = 8'h90; k <= 8'h96; k++) put(8'(k), 16'hDEAD);
        put(8'h97, 16'h1234);
        // 25 (or 24) instructions at 3 cycles plus 9 extra read cycles
        run(a == 16'd0 ? 81 : 84);
        sel = (a == 16'd0) ? 16'h5A5A : b;
        check("R5 add register", mem[8'h90], 16'(a + b));
        check("R6 subtract",     mem[8'h91], 16'(a - b));
        check("R6 multiply low", mem[8'h92], 16'(a * b));
        check("R6 invert",       mem[8'h93], ~a);
        check("R5 add memory",   mem[8'h94], 16'(a + b));
        check("R9 R8 branch path", mem[8'h95], sel);
        check("R11 no-op keeps AC", mem[8'h96], sel);
        check("R11 no-op no write", mem[8'h97], 16'h1234);
    endtask

    initial begin
        logic [15:0] vals [10];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFF,
                 16'h8000, 16'hFFFF, 16'h1234, 16'h00FF, 16'hABCD};
        repeat (3) @(negedge clk);
        check("R1 halted in reset", {15'd0, halted}, 16'd0);
        // R2 R3 R4 R7: sweep programs use every encoding in order
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                sweep_pair(vals[i], vals[j]);
        // R1: AC and DR are cleared by reset even after a prior run
        put(8'd0, ins(4'h1, 12'h040));
        put(8'd1, ins(4'h3, 12'h000));
        put(8'd2, ins(4'h1, 12'h041));
        put(8'd3, ins(4'hF, 12'h000));
        put(8'h40, 16'hFFFF);
        put(8'h41, 16'hFFFF);
        run(12);
        check("R1 AC zero after reset", mem[8'h40], 16'h0000);
        check("R1 DR zero after reset", mem[8'h41], 16'h0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule